// File: doc/BRIEF.md
# SMBus Host Register Front End

This block is the software-facing half of an SMBus host. Software sees a 64-byte I/O window of byte registers: a command byte, a target address byte whose lowest bit picks the direction, two data bytes, a control byte and a status byte. A 32-byte block buffer sits behind one data offset whose index advances on every access. Writing the control byte with its start bit set launches one transaction, whose kind comes from a protocol code held in the control byte.

The block does not drive the bus wires. It turns each start into a single request on a parallel port toward a target-side agent. That request carries the 7-bit address, protocol code, direction, command, a 16-bit data word, a block length and the whole block buffer. The agent answers with one response pulse carrying read data, a returned block and a flag saying whether the addressed target exists and supports the operation. The block writes returned data back into its own registers and raises an error bit when the transaction fails or the protocol code is illegal.

Top module: `smbus_host_regs`

## Requirements
- R1: Offsets are taken from the 6-bit `regSel` (window of 64 bytes): 0x00 status, 0x02 control, 0x03 command, 0x04 address, 0x05 data-low, 0x06 data-high, 0x07 block port. Every other offset reads 0x00 and a write to it changes no register.
- R2: A write to control stores the value; a read of control returns only its bits [4:0], with bits [7:5] read as 0. Command, address and both data registers read back the last value written.
- R3: Writing control with bit 6 set while idle and a legal protocol code (control bits [4:2] equal to 0 quick, 1 byte, 2 byte with command, 3 word, 5 block) raises `reqValid` for exactly the next cycle with `reqAddr` = address[7:1], `reqRead` = address[0], `reqProt` = code, `reqCmd` = command, `reqData` = {data-high, data-low}, `reqLen` = data-low and `reqBlk` byte i (bits 8i+7:8i) = buffer entry i. Status bit 0 (busy) reads 1 from that cycle until the cycle after the response.
- R4: A start with code 4, 6 or 7 issues no request and sets status bit 2 (error) on the next cycle.
- R5: A response with `rspOk` = 0 sets status bit 2 and leaves the data registers and buffer unchanged.
- R6: On a successful read response, codes 1 and 2 load data-low from `rspData[7:0]`; code 3 loads data-low from `rspData[7:0]` and data-high from `rspData[15:8]`; code 5 loads data-low from `rspLen` and buffer entry i from `rspBlk[8i+7:8i]`. Quick commands and write-direction transactions store nothing.
- R7: A start while busy is ignored (no request, busy unchanged), and a response while idle has no effect.
- R8: Any write to status, whatever the value, clears status bit 2 and returns the block index to 0.
- R9: A read of control returns the block index to 0.
- R10: Each read or write of the block port accesses buffer entry [index], then advances the index, which wraps from 31 to 0.
- R11: After reset every register, the buffer, the index, busy and `reqValid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 6 | Byte offset within the register window |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effects) |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Read data for `regSel` |
| reqValid | output | 1 | One-cycle transaction request |
| reqAddr | output | 7 | Target address |
| reqRead | output | 1 | 1 = read direction |
| reqProt | output | 3 | Protocol code |
| reqCmd | output | 8 | Command byte |
| reqData | output | 16 | Write word, low byte from data-low |
| reqLen | output | 8 | Block length |
| reqBlk | output | 256 | Block buffer contents, entry i at bits 8i+7:8i |
| rspValid | input | 1 | Response pulse |
| rspOk | input | 1 | Target present and operation supported |
| rspData | input | 16 | Returned byte or word |
| rspLen | input | 8 | Returned block count |
| rspBlk | input | 256 | Returned block bytes |

## Verification
The bench builds the block with its default parameters: a 6-bit offset and a 32-entry buffer. With those, every one of the 64 offsets can be swept to show the unused ones read zero and ignore writes, and 34 to 35 consecutive block port accesses reach the wrap from entry 31 back to 0 within a short run. The full 256-bit request and response block buses are compared byte for byte against the bench's own buffer model on each request and block read.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;

  localparam int BYTE_W   = 8;
  localparam int TGT_AW   = 7;
  localparam int PROT_W   = 3;

  // register offsets inside the window
  localparam int OFS_STAT = 0;
  localparam int OFS_CTL  = 2;
  localparam int OFS_CMD  = 3;
  localparam int OFS_ADR  = 4;
  localparam int OFS_DLO  = 5;
  localparam int OFS_DHI  = 6;
  localparam int OFS_BLK  = 7;

  // protocol codes
  localparam logic [PROT_W-1:0] PR_QUICK = 3'd0;
  localparam logic [PROT_W-1:0] PR_BYTE  = 3'd1;
  localparam logic [PROT_W-1:0] PR_BCMD  = 3'd2;
  localparam logic [PROT_W-1:0] PR_WORD  = 3'd3;
  localparam logic [PROT_W-1:0] PR_BLOCK = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic wrCtl;
    logic wrCmd;
    logic wrAdr;
    logic wrDlo;
    logic wrDhi;
    logic wrBuf;
    logic stepIdx;
    logic clrIdx;
    logic setErr;
    logic clrErr;
    logic capByte;
    logic capWord;
    logic capBlk;
  } strobe_t;

  function automatic logic protoLegal(input logic [PROT_W-1:0] code);
    return (code == PR_QUICK) || (code == PR_BYTE) || (code == PR_BCMD) ||
           (code == PR_WORD) || (code == PR_BLOCK);
  endfunction

endpackage

// File: rtl/smbus_host_ctrl.sv
module smbus_host_ctrl
  import smbus_host_pkg::*;
#(
  parameter int WIN_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIN_AW-1:0] regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              startBit,
  input  logic [PROT_W-1:0] codeIn,
  input  logic              addrDir,
  input  logic              rspValid,
  input  logic              rspOk,
  output strobe_t           stb,
  output logic              hostBusy,
  output logic              reqValid
);

  logic              busyQ;
  logic              reqQ;
  logic [PROT_W-1:0] capProtQ;
  logic              capReadQ;

  logic selStat, selCtl, selCmd, selAdr, selDlo, selDhi, selBlk;
  logic startHit, startGood, rspTake, rspGood;

  assign selStat = (regSel == WIN_AW'(OFS_STAT));
  assign selCtl  = (regSel == WIN_AW'(OFS_CTL));
  assign selCmd  = (regSel == WIN_AW'(OFS_CMD));
  assign selAdr  = (regSel == WIN_AW'(OFS_ADR));
  assign selDlo  = (regSel == WIN_AW'(OFS_DLO));
  assign selDhi  = (regSel == WIN_AW'(OFS_DHI));
  assign selBlk  = (regSel == WIN_AW'(OFS_BLK));

  assign startHit  = regWr && selCtl && startBit && !busyQ;
  assign startGood = startHit && protoLegal(codeIn);
  assign rspTake   = busyQ && rspValid;
  assign rspGood   = rspTake && rspOk && capReadQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      reqQ     <= 1'b0;
      capProtQ <= '0;
      capReadQ <= 1'b0;
    end else begin
      reqQ <= startGood;
      if (startGood) begin
        busyQ    <= 1'b1;
        capProtQ <= codeIn;
        capReadQ <= addrDir;
      end else if (rspTake) begin
        busyQ <= 1'b0;
      end
    end
  end

  always_comb begin
    stb         = '0;
    stb.wrCtl   = regWr && selCtl;
    stb.wrCmd   = regWr && selCmd;
    stb.wrAdr   = regWr && selAdr;
    stb.wrDlo   = regWr && selDlo;
    stb.wrDhi   = regWr && selDhi;
    stb.wrBuf   = regWr && selBlk;
    stb.stepIdx = (regWr || regRd) && selBlk;
    stb.clrIdx  = (regWr && selStat) || (regRd && selCtl);
    stb.setErr  = (startHit && !protoLegal(codeIn)) || (rspTake && !rspOk);
    stb.clrErr  = regWr && selStat;
    stb.capByte = rspGood && ((capProtQ == PR_BYTE) || (capProtQ == PR_BCMD));
    stb.capWord = rspGood && (capProtQ == PR_WORD);
    stb.capBlk  = rspGood && (capProtQ == PR_BLOCK);
  end

  assign hostBusy = busyQ;
  assign reqValid = reqQ;

endmodule

// File: rtl/smbus_host_dp.sv
module smbus_host_dp
  import smbus_host_pkg::*;
#(
  parameter int WIN_AW    = 6,
  parameter int BLK_DEPTH = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     stb,
  input  logic [WIN_AW-1:0]           regSel,
  input  logic [BYTE_W-1:0]           regWdata,
  input  logic                        hostBusy,
  input  logic [2*BYTE_W-1:0]         rspData,
  input  logic [BYTE_W-1:0]           rspLen,
  input  logic [BLK_DEPTH*BYTE_W-1:0] rspBlk,
  output logic [BYTE_W-1:0]           regRdata,
  output logic                        addrDir,
  output logic [PROT_W-1:0]           codeOut,
  output logic                        hostErr,
  output logic [TGT_AW-1:0]           reqAddr,
  output logic                        reqRead,
  output logic [PROT_W-1:0]           reqProt,
  output logic [BYTE_W-1:0]           reqCmd,
  output logic [2*BYTE_W-1:0]         reqData,
  output logic [BYTE_W-1:0]           reqLen,
  output logic [BLK_DEPTH*BYTE_W-1:0] reqBlk
);

  localparam int IDX_W   = $clog2(BLK_DEPTH);
  localparam int CTL_KEEP = 5;

  logic [CTL_KEEP-1:0]                ctlQ;
  logic [BYTE_W-1:0]                  cmdQ, adrQ, dloQ, dhiQ;
  logic                               errQ;
  logic [IDX_W-1:0]                   idxQ;
  logic [BLK_DEPTH-1:0][BYTE_W-1:0]   bufQ;
  logic [IDX_W-1:0]                   idxNext;

  assign idxNext = (idxQ == IDX_W'(BLK_DEPTH - 1)) ? '0 : idxQ + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ <= '0;
      cmdQ <= '0;
      adrQ <= '0;
      dloQ <= '0;
      dhiQ <= '0;
      errQ <= 1'b0;
      idxQ <= '0;
    end else begin
      if (stb.wrCtl) ctlQ <= regWdata[CTL_KEEP-1:0];
      if (stb.wrCmd) cmdQ <= regWdata;
      if (stb.wrAdr) adrQ <= regWdata;

      if (stb.capByte || stb.capWord) dloQ <= rspData[BYTE_W-1:0];
      else if (stb.capBlk)            dloQ <= rspLen;
      else if (stb.wrDlo)             dloQ <= regWdata;

      if (stb.capWord)    dhiQ <= rspData[2*BYTE_W-1:BYTE_W];
      else if (stb.wrDhi) dhiQ <= regWdata;

      if (stb.setErr)      errQ <= 1'b1;
      else if (stb.clrErr) errQ <= 1'b0;

      if (stb.clrIdx)       idxQ <= '0;
      else if (stb.stepIdx) idxQ <= idxNext;
    end
  end

  // block buffer: a returned block replaces every entry at once
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufQ <= '0;
    end else if (stb.capBlk) begin
      for (int i = 0; i < BLK_DEPTH; i++) begin
        bufQ[i] <= rspBlk[i*BYTE_W +: BYTE_W];
      end
    end else if (stb.wrBuf) begin
      bufQ[idxQ] <= regWdata;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regSel == WIN_AW'(OFS_STAT)) begin
      regRdata[0] = hostBusy;
      regRdata[2] = errQ;
    end
    else if (regSel == WIN_AW'(OFS_CTL)) regRdata = {{(BYTE_W-CTL_KEEP){1'b0}}, ctlQ};
    else if (regSel == WIN_AW'(OFS_CMD)) regRdata = cmdQ;
    else if (regSel == WIN_AW'(OFS_ADR)) regRdata = adrQ;
    else if (regSel == WIN_AW'(OFS_DLO)) regRdata = dloQ;
    else if (regSel == WIN_AW'(OFS_DHI)) regRdata = dhiQ;
    else if (regSel == WIN_AW'(OFS_BLK)) regRdata = bufQ[idxQ];
  end

  assign addrDir = adrQ[0];
  assign codeOut = ctlQ[4:2];
  assign hostErr = errQ;
  assign reqAddr = adrQ[BYTE_W-1:1];
  assign reqRead = adrQ[0];
  assign reqProt = ctlQ[4:2];
  assign reqCmd  = cmdQ;
  assign reqData = {dhiQ, dloQ};
  assign reqLen  = dloQ;
  assign reqBlk  = bufQ;

endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
  import smbus_host_pkg::*;
#(
  parameter int WIN_AW    = 6,
  parameter int BLK_DEPTH = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [WIN_AW-1:0]           regSel,
  input  logic                        regWr,
  input  logic                        regRd,
  input  logic [7:0]                  regWdata,
  output logic [7:0]                  regRdata,
  output logic                        reqValid,
  output logic [6:0]                  reqAddr,
  output logic                        reqRead,
  output logic [2:0]                  reqProt,
  output logic [7:0]                  reqCmd,
  output logic [15:0]                 reqData,
  output logic [7:0]                  reqLen,
  output logic [BLK_DEPTH*8-1:0]      reqBlk,
  input  logic                        rspValid,
  input  logic                        rspOk,
  input  logic [15:0]                 rspData,
  input  logic [7:0]                  rspLen,
  input  logic [BLK_DEPTH*8-1:0]      rspBlk
);

  strobe_t           stb;
  logic              hostBusy;
  logic              hostErr;
  logic              addrDir;
  logic [PROT_W-1:0] codeOut;

  smbus_host_ctrl #(.WIN_AW(WIN_AW)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regSel   (regSel),
    .regWr    (regWr),
    .regRd    (regRd),
    .startBit (regWdata[6]),
    .codeIn   (regWdata[4:2]),
    .addrDir  (addrDir),
    .rspValid (rspValid),
    .rspOk    (rspOk),
    .stb      (stb),
    .hostBusy (hostBusy),
    .reqValid (reqValid)
  );

  smbus_host_dp #(.WIN_AW(WIN_AW), .BLK_DEPTH(BLK_DEPTH)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regSel   (regSel),
    .regWdata (regWdata),
    .hostBusy (hostBusy),
    .rspData  (rspData),
    .rspLen   (rspLen),
    .rspBlk   (rspBlk),
    .regRdata (regRdata),
    .addrDir  (addrDir),
    .codeOut  (codeOut),
    .hostErr  (hostErr),
    .reqAddr  (reqAddr),
    .reqRead  (reqRead),
    .reqProt  (reqProt),
    .reqCmd   (reqCmd),
    .reqData  (reqData),
    .reqLen   (reqLen),
    .reqBlk   (reqBlk)
  );

endmodule

// File: rtl/smbus_host_chk.sv
module smbus_host_chk
  import smbus_host_pkg::*;
#(
  parameter int WIN_AW = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [WIN_AW-1:0] regSel,
  input logic              regWr,
  input logic              startBit,
  input logic [2:0]        codeIn,
  input logic              reqValid,
  input logic [2:0]        reqProt,
  input logic              rspValid,
  input logic              rspOk,
  input logic              hostBusy,
  input logic              hostErr
);

  logic ctlStart, statWr, failRsp;
  assign ctlStart = regWr && (regSel == WIN_AW'(OFS_CTL)) && startBit && !hostBusy;
  assign statWr   = regWr && (regSel == WIN_AW'(OFS_STAT));
  assign failRsp  = hostBusy && rspValid && !rspOk;

  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid); // R3

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (hostBusy && protoLegal(reqProt))); // R3

  AST_RSP_RELEASES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (hostBusy && rspValid) |=> !hostBusy); // R3

  AST_ILLEGAL_CODE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStart && !protoLegal(codeIn)) |=> (hostErr && !reqValid && !hostBusy)); // R4

  AST_FAIL_RSP_ERR: assert property (@(posedge clk) disable iff (!rstN)
    failRsp |=> hostErr); // R5

  AST_BUSY_BLOCKS_START: assert property (@(posedge clk) disable iff (!rstN)
    hostBusy |=> !reqValid); // R7

  AST_IDLE_RSP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (!hostBusy && rspValid && !ctlStart && !statWr) |=> ($stable(hostErr) && !hostBusy)); // R7

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && !failRsp) |=> !hostErr); // R8

endmodule

bind smbus_host_regs smbus_host_chk #(.WIN_AW(WIN_AW)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .regSel   (regSel),
  .regWr    (regWr),
  .startBit (regWdata[6]),
  .codeIn   (regWdata[4:2]),
  .reqValid (reqValid),
  .reqProt  (reqProt),
  .rspValid (rspValid),
  .rspOk    (rspOk),
  .hostBusy (hostBusy),
  .hostErr  (hostErr)
);

// File: tb/smbus_host_regs_tb_top.sv
`timescale 1ns/1ps
module smbus_host_regs_tb_top;

  localparam int DEPTH = 32;
  localparam int BB    = DEPTH * 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [5:0]    regSel = '0;
  logic          regWr = 1'b0, regRd = 1'b0;
  logic [7:0]    regWdata = '0;
  logic [7:0]    regRdata;
  logic          reqValid, reqRead;
  logic [6:0]    reqAddr;
  logic [2:0]    reqProt;
  logic [7:0]    reqCmd, reqLen;
  logic [15:0]   reqData;
  logic [BB-1:0] reqBlk;
  logic          rspValid = 1'b0, rspOk = 1'b0;
  logic [15:0]   rspData = '0;
  logic [7:0]    rspLen = '0;
  logic [BB-1:0] rspBlk = '0;

  always #2 clk = ~clk;

  smbus_host_regs dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqRead(reqRead), .reqProt(reqProt), .reqCmd(reqCmd),
    .reqData(reqData), .reqLen(reqLen), .reqBlk(reqBlk), .rspValid(rspValid),
    .rspOk(rspOk), .rspData(rspData), .rspLen(rspLen), .rspBlk(rspBlk)
  );

  int    nChk = 0, nFail = 0;
  bit    done = 1'b0;
  string curReq = "R11";

  // behavioural reference state
  logic [7:0] mCtl = 0, mCmd = 0, mAdr = 0, mDlo = 0, mDhi = 0;
  logic [7:0] mBuf [DEPTH];
  int         mIdx = 0;
  bit         mBusy = 0, mErr = 0, mReq = 0, mCapRd = 0;
  int         mCapP = 0;

  initial for (int i = 0; i < DEPTH; i++) mBuf[i] = 8'h00;

  task automatic chk(string tag, logic [BB-1:0] act, logic [BB-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRd(logic [5:0] s);
    case (s)
      6'd0:    return {5'b0, mErr, 1'b0, mBusy};
      6'd2:    return {3'b0, mCtl[4:0]};
      6'd3:    return mCmd;
      6'd4:    return mAdr;
      6'd5:    return mDlo;
      6'd6:    return mDhi;
      6'd7:    return mBuf[mIdx];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [BB-1:0] packBuf();
    logic [BB-1:0] v;
    for (int i = 0; i < DEPTH; i++) v[i*8 +: 8] = mBuf[i];
    return v;
  endfunction

  function automatic bit legal(int p);
    return (p == 0) || (p == 1) || (p == 2) || (p == 3) || (p == 5);
  endfunction

  task automatic modelStep();
    bit oldBusy = mBusy;
    bit nReq = 0;
    if (regWr) begin
      case (regSel)
        6'd0: begin mErr = 0; mIdx = 0; end
        6'd2: begin
          mCtl = regWdata;
          if (regWdata[6] && !oldBusy) begin
            if (legal(int'(regWdata[4:2]))) begin
              nReq = 1; mBusy = 1; mCapP = int'(regWdata[4:2]); mCapRd = mAdr[0];
            end else mErr = 1;
          end
        end
        6'd3: mCmd = regWdata;
        6'd4: mAdr = regWdata;
        6'd5: mDlo = regWdata;
        6'd6: mDhi = regWdata;
        6'd7: begin mBuf[mIdx] = regWdata; mIdx = (mIdx + 1) % DEPTH; end
        default: ;
      endcase
    end
    if (regRd) begin
      if (regSel == 6'd2) mIdx = 0;
      if (regSel == 6'd7) mIdx = (mIdx + 1) % DEPTH;
    end
    if (rspValid && oldBusy) begin
      mBusy = 0;
      if (!rspOk) mErr = 1;
      else if (mCapRd) begin
        if (mCapP == 1 || mCapP == 2) mDlo = rspData[7:0];
        else if (mCapP == 3) begin mDlo = rspData[7:0]; mDhi = rspData[15:8]; end
        else if (mCapP == 5) begin
          mDlo = rspLen;
          for (int i = 0; i < DEPTH; i++) mBuf[i] = rspBlk[i*8 +: 8];
        end
      end
    end
    mReq = nReq;
  endtask

  // compare before the edge, then advance the model with the same inputs
  task automatic tick();
    #1;
    chk(curReq, regRdata, expRd(regSel));
    chk("R3", reqValid, mReq);
    if (mReq) begin
      chk("R3", reqAddr, mAdr[7:1]);
      chk("R3", reqRead, mAdr[0]);
      chk("R3", reqProt, mCtl[4:2]);
      chk("R3", reqCmd, mCmd);
      chk("R3", reqData, {mDhi, mDlo});
      chk("R3", reqLen, mDlo);
      chk("R3", reqBlk, packBuf());
    end
    @(posedge clk);
    modelStep();
    #1;
  endtask

  task automatic wrReg(int ofs, int val);
    regSel = 6'(ofs); regWr = 1; regWdata = 8'(val);
    tick();
    regWr = 0;
  endtask

  task automatic rdReg(int ofs);
    regSel = 6'(ofs); regRd = 1;
    tick();
    regRd = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic respond(bit ok, logic [15:0] d, logic [7:0] l, logic [BB-1:0] b);
    rspValid = 1; rspOk = ok; rspData = d; rspLen = l; rspBlk = b;
    tick();
    rspValid = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [BB-1:0] pat;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(posedge clk); #1;

    // R11 reset values
    curReq = "R11";
    for (int o = 0; o < 8; o++) rdReg(o);

    // R1 register readback and unused offsets
    curReq = "R1";
    wrReg(3, 8'hA5); wrReg(4, 8'h3C); wrReg(5, 8'h11); wrReg(6, 8'h22);
    wrReg(1, 8'hFF); wrReg(8, 8'hFF); wrReg(63, 8'hFF); wrReg(31, 8'h55);
    for (int o = 0; o < 64; o++) begin regSel = 6'(o); tick(); end

    // R2 control readback masks the top bits
    curReq = "R2";
    wrReg(2, 8'hA3); rdReg(2);
    wrReg(2, 8'h1F); rdReg(2);
    wrReg(3, 8'h00); rdReg(3);

    // R6 read byte with command
    curReq = "R6";
    wrReg(4, (8'h50 << 1) | 1); wrReg(3, 8'h10);
    wrReg(2, 8'h48);
    regSel = 0; idle(2);
    // R7 start while busy ignored
    curReq = "R7";
    wrReg(2, 8'h4C); regSel = 0; idle(1);
    curReq = "R6";
    respond(1, 16'h005A, 8'h00, '0);
    rdReg(5); rdReg(0);

    // R7 response while idle ignored
    curReq = "R7";
    respond(1, 16'h7777, 8'h09, {DEPTH{8'hEE}});
    rdReg(5); rdReg(0); rdReg(7);

    // R6 word read
    curReq = "R6";
    wrReg(2, 8'h4C); regSel = 5; idle(1);
    respond(1, 16'hBEEF, 8'h00, '0);
    rdReg(5); rdReg(6);

    // R3 word write: request carries both bytes, nothing stored back
    curReq = "R3";
    wrReg(4, 8'h50 << 1); wrReg(5, 8'h34); wrReg(6, 8'h12); wrReg(3, 8'h07);
    wrReg(2, 8'h4C); regSel = 0; idle(1);
    respond(1, 16'hFFFF, 8'h00, '0);
    rdReg(5); rdReg(6);

    // R1 quick and send byte requests (codes 0 and 1)
    curReq = "R1";
    wrReg(2, 8'h40); respond(1, 16'h00AA, 8'h00, '0); rdReg(5);
    wrReg(2, 8'h44); respond(1, 16'h00AB, 8'h00, '0); rdReg(5);
    // R6 receive byte
    curReq = "R6";
    wrReg(4, (8'h51 << 1) | 1);
    wrReg(2, 8'h44); respond(1, 16'h00C3, 8'h00, '0); rdReg(5);

    // R10 block port writes with wrap, R8 index reset by status write
    curReq = "R10";
    wrReg(0, 8'h00);
    for (int i = 0; i < 35; i++) wrReg(7, 8'h80 + i);
    rdReg(7);
    curReq = "R8";
    wrReg(0, 8'h5A); rdReg(7); rdReg(7);

    // R3 block write request with full buffer
    curReq = "R3";
    wrReg(4, 8'h52 << 1); wrReg(5, 8'h20); wrReg(3, 8'h01);
    wrReg(2, 8'h54); regSel = 0; idle(1);
    respond(1, 16'h0000, 8'h99, '0);
    rdReg(5);

    // R6 block read fills the buffer, R9 control read resets index
    curReq = "R6";
    for (int i = 0; i < DEPTH; i++) pat[i*8 +: 8] = 8'(i * 7 + 1);
    wrReg(4, (8'h52 << 1) | 1);
    wrReg(2, 8'h54); regSel = 0; idle(2);
    respond(1, 16'h0000, 8'h05, pat);
    rdReg(5);
    curReq = "R9";
    rdReg(7); rdReg(7); rdReg(2);
    curReq = "R10";
    for (int i = 0; i < 34; i++) rdReg(7);

    // R4 illegal protocol codes
    curReq = "R4";
    wrReg(2, 8'h50); rdReg(0);
    curReq = "R8"; wrReg(0, 8'h00); rdReg(0);
    curReq = "R4";
    wrReg(2, 8'h58); rdReg(0); wrReg(0, 8'hFF);
    wrReg(2, 8'h5C); rdReg(0);
    curReq = "R8"; wrReg(0, 8'h04); rdReg(0);

    // R5 failed response leaves data untouched
    curReq = "R5";
    wrReg(4, (8'h60 << 1) | 1);
    wrReg(2, 8'h4C); regSel = 0; idle(1);
    respond(0, 16'h4321, 8'h03, {DEPTH{8'h33}});
    rdReg(0); rdReg(5); rdReg(6); rdReg(7);

    finishRun();
  end

endmodule